// File: doc/BRIEF.md
# SPI serial clock and chip-select timing generator

This block paces one SPI master transaction on the system clock. A start pulse opens the chip select. After a programmable setup delay it toggles the serial clock for a programmed number of bit periods. A programmable hold delay follows before the select is released. The select then stays inactive for a programmable idle gap before another transaction is accepted. Every interval is counted in system clock cycles. Every count field holds the wanted length minus one, so a field of zero lasts one cycle.

The shift engine that moves the data sits beside this block and takes two one-cycle strobes from it. One marks the cycle in which the serial clock leaves its idle level. The other marks the cycle in which the clock returns to it. The engine maps the two strobes to launch and sample according to its clock phase setting. Clock idle level and select polarity are inputs. All configuration is captured when a start is accepted, so the next transaction can be set up while the current one runs.

Top module: `spi_sck_cs_timer`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `sck` equals `cpol`, `cs` equals the inverse of `cs_active_high`, and `lead_stb`, `trail_stb` and `busy` are 0.
- R2: Each interval field encodes its length minus one: a field value v gives v+1 cycles, and 0 gives exactly one cycle.
- R3: A start seen while `busy` is 0 is accepted. From the next cycle, `cs` is active for cfg_cs_setup+1 cycles with `sck` at its idle level before the first clock edge.
- R4: Each bit takes two phases. The first phase, with `sck` away from idle, lasts the high count+1 when `cpol`=0 and the low count+1 when `cpol`=1. The second phase, back at idle, lasts the other count+1. cfg_bits+1 bits are sent.
- R5: After the last bit's second phase, `cs` stays active with `sck` idle for cfg_cs_hold+1 cycles and is then released.
- R6: After release, `cs` stays inactive for cfg_cs_idle+1 cycles (an 8-bit field) with `busy` still 1. A start in any of these cycles, the last one included, is ignored. A start in the first cycle after that is accepted.
- R7: `busy` is 1 from the cycle after an accepted start through the last idle-gap cycle. A start while `busy` is 1 has no effect.
- R8: `lead_stb` is high for exactly the first cycle of each first phase, and `trail_stb` for exactly the first cycle of each second phase. Each fires once per bit, and they never fire together.
- R9: The active level of `cs` is 1 when `cs_active_high`=1 and 0 otherwise. The idle level of `sck` is `cpol`.
- R10: With `ext_mode`=0, only bits [7:0] of the clock high, clock low, setup and hold fields count. With `ext_mode`=1, all 16 bits count.
- R11: Configuration, `cpol` and `cs_active_high` are captured when a start is accepted. Changing them during a transaction does not alter that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transaction |
| ext_mode | input | 1 | 1: 16-bit clock/setup/hold fields; 0: low 8 bits only |
| cfg_sck_high | input | 16 | Serial clock high time minus one |
| cfg_sck_low | input | 16 | Serial clock low time minus one |
| cfg_cs_setup | input | 16 | Select-to-first-edge delay minus one |
| cfg_cs_hold | input | 16 | Last-edge-to-release delay minus one |
| cfg_cs_idle | input | 8 | Inactive gap after release minus one |
| cfg_bits | input | 8 | Number of bit periods minus one |
| cpol | input | 1 | Serial clock idle level |
| cs_active_high | input | 1 | 1: select asserted high; 0: asserted low |
| sck | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| lead_stb | output | 1 | First cycle of a phase away from idle |
| trail_stb | output | 1 | First cycle of a phase back at idle |
| busy | output | 1 | Transaction or idle gap in progress |

## Verification
Two functions can fall in the same cycle. One is the end of the idle gap. The other is the acceptance of a new start. The bench provokes this by holding `start` high through whole transactions, so a request lands on the last gap cycle (it must be ignored) and again on the first free cycle (it must be accepted). The reference model decides acceptance from whether it predicted the design idle in that cycle, then compares every output on every clock. It also counts the `busy` rising edges against the transactions it accepted.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

  typedef enum logic [2:0] {
    ST_REST,
    ST_LEAD_IN,
    ST_PH_A,
    ST_PH_B,
    ST_TAIL,
    ST_GAP
  } tmg_state_e;

  // Select is driven active in these phases only.
  function automatic logic cs_engaged(input tmg_state_e s);
    return (s == ST_LEAD_IN) || (s == ST_PH_A) || (s == ST_PH_B) || (s == ST_TAIL);
  endfunction

endpackage

// File: rtl/spi_tmg_seq.sv
module spi_tmg_seq
  import spi_tmg_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned IDLE_W = 8,
  parameter int unsigned BITS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [CNT_W-1:0]  high_m1,
  input  logic [CNT_W-1:0]  low_m1,
  input  logic [CNT_W-1:0]  setup_m1,
  input  logic [CNT_W-1:0]  hold_m1,
  input  logic [IDLE_W-1:0] idle_m1,
  input  logic [BITS_W-1:0] bits_m1,
  input  logic              cpol,
  input  logic              cs_high,
  output tmg_state_e        state,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  phase_len,
  output logic              first_cyc,
  output logic              accept,
  output logic              cpol_q,
  output logic              cs_high_q
);

  localparam int unsigned EXT_BITS = CNT_W - BASE_W;

  logic [CNT_W-1:0]  high_n, low_n, setup_n, hold_n;
  logic [CNT_W-1:0]  high_q, low_q, setup_q, hold_q;
  logic [IDLE_W-1:0] idle_q;
  logic [BITS_W-1:0] bits_q, bit_idx;
  logic              phase_end;

  // Field width selection: narrow mode drops the upper bits.
  generate
    if (CNT_W > BASE_W) begin : g_narrow
      function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic wide);
        return wide ? v : {{EXT_BITS{1'b0}}, v[BASE_W-1:0]};
      endfunction
      assign high_n  = fit(high_m1, ext_mode);
      assign low_n   = fit(low_m1, ext_mode);
      assign setup_n = fit(setup_m1, ext_mode);
      assign hold_n  = fit(hold_m1, ext_mode);
    end else begin : g_flat
      assign high_n  = high_m1;
      assign low_n   = low_m1;
      assign setup_n = setup_m1;
      assign hold_n  = hold_m1;
    end
  endgenerate

  assign accept = start && (state == ST_REST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q    <= '0;
      low_q     <= '0;
      setup_q   <= '0;
      hold_q    <= '0;
      idle_q    <= '0;
      bits_q    <= '0;
      cpol_q    <= 1'b0;
      cs_high_q <= 1'b0;
    end else if (accept) begin
      high_q    <= high_n;
      low_q     <= low_n;
      setup_q   <= setup_n;
      hold_q    <= hold_n;
      idle_q    <= idle_m1;
      bits_q    <= bits_m1;
      cpol_q    <= cpol;
      cs_high_q <= cs_high;
    end
  end

  // Length (minus one) of the phase now running.
  always_comb begin
    unique case (state)
      ST_LEAD_IN: phase_len = setup_q;
      ST_PH_A:    phase_len = cpol_q ? low_q : high_q;
      ST_PH_B:    phase_len = cpol_q ? high_q : low_q;
      ST_TAIL:    phase_len = hold_q;
      ST_GAP:     phase_len = CNT_W'(idle_q);
      default:    phase_len = '0;
    endcase
  end

  assign phase_end = (cnt == phase_len);
  assign first_cyc = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_REST;
      cnt     <= '0;
      bit_idx <= '0;
    end else if (state == ST_REST) begin
      cnt     <= '0;
      bit_idx <= '0;
      if (start) state <= ST_LEAD_IN;
    end else if (!phase_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      unique case (state)
        ST_LEAD_IN: state <= ST_PH_A;
        ST_PH_A:    state <= ST_PH_B;
        ST_PH_B: begin
          if (bit_idx == bits_q) begin
            state <= ST_TAIL;
          end else begin
            state   <= ST_PH_A;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_TAIL: state <= ST_GAP;
        default: state <= ST_REST;
      endcase
    end
  end

endmodule

// File: rtl/spi_tmg_drive.sv
module spi_tmg_drive
  import spi_tmg_pkg::*;
(
  input  tmg_state_e state,
  input  logic       first_cyc,
  input  logic       cpol_q,
  input  logic       cs_high_q,
  input  logic       cpol,
  input  logic       cs_high,
  output logic       sck,
  output logic       cs,
  output logic       lead_stb,
  output logic       trail_stb,
  output logic       busy
);

  logic cpol_sel, cs_sel;

  assign busy      = (state != ST_REST);
  // At rest the live polarity settings drive the pins.
  assign cpol_sel  = busy ? cpol_q : cpol;
  assign cs_sel    = busy ? cs_high_q : cs_high;
  assign sck       = cpol_sel ^ (state == ST_PH_A);
  assign cs        = cs_engaged(state) ? cs_sel : ~cs_sel;
  assign lead_stb  = (state == ST_PH_A) && first_cyc;
  assign trail_stb = (state == ST_PH_B) && first_cyc;

endmodule

// File: rtl/spi_sck_cs_timer.sv
module spi_sck_cs_timer
  import spi_tmg_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned IDLE_W = 8,
  parameter int unsigned BITS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [CNT_W-1:0]  cfg_sck_high,
  input  logic [CNT_W-1:0]  cfg_sck_low,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_cs_hold,
  input  logic [IDLE_W-1:0] cfg_cs_idle,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic              cpol,
  input  logic              cs_active_high,
  output logic              sck,
  output logic              cs,
  output logic              lead_stb,
  output logic              trail_stb,
  output logic              busy
);

  tmg_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phase_len;
  logic             first_cyc;
  logic             accept;
  logic             cpol_q;
  logic             cs_high_q;

  spi_tmg_seq #(
    .CNT_W (CNT_W),
    .BASE_W(BASE_W),
    .IDLE_W(IDLE_W),
    .BITS_W(BITS_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ext_mode (ext_mode),
    .high_m1  (cfg_sck_high),
    .low_m1   (cfg_sck_low),
    .setup_m1 (cfg_cs_setup),
    .hold_m1  (cfg_cs_hold),
    .idle_m1  (cfg_cs_idle),
    .bits_m1  (cfg_bits),
    .cpol     (cpol),
    .cs_high  (cs_active_high),
    .state    (state),
    .cnt      (cnt),
    .phase_len(phase_len),
    .first_cyc(first_cyc),
    .accept   (accept),
    .cpol_q   (cpol_q),
    .cs_high_q(cs_high_q)
  );

  spi_tmg_drive u_drive (
    .state    (state),
    .first_cyc(first_cyc),
    .cpol_q   (cpol_q),
    .cs_high_q(cs_high_q),
    .cpol     (cpol),
    .cs_high  (cs_active_high),
    .sck      (sck),
    .cs       (cs),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb),
    .busy     (busy)
  );

endmodule

// File: rtl/spi_sck_cs_timer_chk.sv
module spi_sck_cs_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sck,
  input logic             cs,
  input logic             lead_stb,
  input logic             trail_stb,
  input logic             accept,
  input logic             cpol_q,
  input logic             cs_high_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] phase_len
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb)); // R8

  AST_REST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lead_stb && !trail_stb)); // R7

  AST_ACCEPT_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && (cs == cs_high_q) && (sck == cpol_q) && !lead_stb)); // R3

  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> ((sck != cpol_q) && (cs == cs_high_q))); // R9

  AST_TRAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> ((sck == cpol_q) && (cs == cs_high_q))); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= phase_len)); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cpol_q) && $stable(cs_high_q))); // R11

endmodule

bind spi_sck_cs_timer spi_sck_cs_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .sck      (sck),
  .cs       (cs),
  .lead_stb (lead_stb),
  .trail_stb(trail_stb),
  .accept   (accept),
  .cpol_q   (cpol_q),
  .cs_high_q(cs_high_q),
  .cnt      (cnt),
  .phase_len(phase_len)
);

// File: tb/spi_sck_cs_timer_bench.sv
`timescale 1ns/1ps
module spi_sck_cs_timer_bench;

  localparam int CNT_W  = 16;
  localparam int BASE_W = 8;
  localparam int IDLE_W = 8;
  localparam int BITS_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0, start = 1'b0, ext_mode = 1'b0;
  logic              cpol = 1'b0, cs_active_high = 1'b0;
  logic [CNT_W-1:0]  cfg_sck_high = '0, cfg_sck_low = '0, cfg_cs_setup = '0, cfg_cs_hold = '0;
  logic [IDLE_W-1:0] cfg_cs_idle = '0;
  logic [BITS_W-1:0] cfg_bits = '0;
  logic              sck, cs, lead_stb, trail_stb, busy;

  spi_sck_cs_timer #(.CNT_W(CNT_W), .BASE_W(BASE_W), .IDLE_W(IDLE_W), .BITS_W(BITS_W)) u_spi_sck_cs_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_mode),
    .cfg_sck_high(cfg_sck_high), .cfg_sck_low(cfg_sck_low),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_hold(cfg_cs_hold),
    .cfg_cs_idle(cfg_cs_idle), .cfg_bits(cfg_bits),
    .cpol(cpol), .cs_active_high(cs_active_high),
    .sck(sck), .cs(cs), .lead_stb(lead_stb), .trail_stb(trail_stb), .busy(busy)
  );

  typedef struct packed {logic sck; logic cs; logic lead; logic trail; logic busy;} cyc_t;
  cyc_t model_q[$];

  int n_checks = 0, n_fails = 0, cyc = 0;
  int seen_lead = 0, seen_cs_act = 0, seen_busy = 0, busy_rises = 0, n_push = 0;
  logic txn_pol = 1'b0, prev_busy = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int fit(input int v, input bit wide);
    return wide ? v : (v & 255);
  endfunction

  // Expected transaction lengths in cycles, from the current inputs.
  function automatic int cs_len();
    int hi = fit(int'(cfg_sck_high), ext_mode) + 1;
    int lo = fit(int'(cfg_sck_low), ext_mode) + 1;
    return fit(int'(cfg_cs_setup), ext_mode) + 1 + (int'(cfg_bits) + 1) * (hi + lo)
           + fit(int'(cfg_cs_hold), ext_mode) + 1;
  endfunction

  task automatic push_txn();
    int su = fit(int'(cfg_cs_setup), ext_mode) + 1;
    int hi = fit(int'(cfg_sck_high), ext_mode) + 1;
    int lo = fit(int'(cfg_sck_low), ext_mode) + 1;
    int ho = fit(int'(cfg_cs_hold), ext_mode) + 1;
    int gap = int'(cfg_cs_idle) + 1;
    int nb = int'(cfg_bits) + 1;
    int first = cpol ? lo : hi;
    int second = cpol ? hi : lo;
    logic p = cpol;
    logic a = cs_active_high;
    n_push++;
    repeat (su) model_q.push_back('{p, a, 1'b0, 1'b0, 1'b1});
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < first; i++) model_q.push_back('{~p, a, (i == 0), 1'b0, 1'b1});
      for (int i = 0; i < second; i++) model_q.push_back('{p, a, 1'b0, (i == 0), 1'b1});
    end
    repeat (ho) model_q.push_back('{p, a, 1'b0, 1'b0, 1'b1});
    repeat (gap) model_q.push_back('{p, ~a, 1'b0, 1'b0, 1'b1});
  endtask

  // One clock: compare against the model, then drive start for the next edge.
  task automatic tick(input logic st);
    cyc_t e;
    bit was_idle;
    @(negedge clk);
    cyc++;
    was_idle = (model_q.size() == 0);
    if (was_idle) e = '{cpol, ~cs_active_high, 1'b0, 1'b0, 1'b0};
    else e = model_q.pop_front();
    check(sck == e.sck, "R4", "sck", sck, e.sck);
    check(cs == e.cs, "R9", "cs", cs, e.cs);
    check(lead_stb == e.lead, "R8", "lead_stb", lead_stb, e.lead);
    check(trail_stb == e.trail, "R8", "trail_stb", trail_stb, e.trail);
    check(busy == e.busy, "R7", "busy", busy, e.busy);
    if (lead_stb) seen_lead++;
    if (busy) seen_busy++;
    if (busy && (cs == txn_pol)) seen_cs_act++;
    if (busy && !prev_busy) busy_rises++;
    prev_busy = busy;
    start = st;
    if (st && was_idle) push_txn();
  endtask

  task automatic run_txn(input string tag);
    int exp_cs = cs_len();
    int exp_busy = exp_cs + int'(cfg_cs_idle) + 1;
    int exp_lead = int'(cfg_bits) + 1;
    txn_pol = cs_active_high;
    seen_lead = 0; seen_cs_act = 0; seen_busy = 0;
    tick(1'b1);
    while (model_q.size() != 0) tick(1'b0);
    check(seen_lead == exp_lead, "R8", {tag, " lead count"}, seen_lead, exp_lead);
    check(seen_cs_act == exp_cs, "R3", {tag, " cs active cycles (setup+bits+hold, R5)"}, seen_cs_act, exp_cs);
    check(seen_busy == exp_busy, "R6", {tag, " busy cycles incl. idle gap"}, seen_busy, exp_busy);
  endtask

  task automatic set_cfg(input int hi, input int lo, input int su, input int ho, input int gap, input int nb);
    cfg_sck_high = CNT_W'(hi); cfg_sck_low = CNT_W'(lo);
    cfg_cs_setup = CNT_W'(su); cfg_cs_hold = CNT_W'(ho);
    cfg_cs_idle = IDLE_W'(gap); cfg_bits = BITS_W'(nb);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL R7 watchdog: actual still running, expected completion");
    finish_run();
  end

  initial begin
    int exp_lead;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sck == 1'b0, "R1", "sck in reset", sck, 0);
    check(cs == 1'b1, "R1", "cs in reset", cs, 1);
    check(!lead_stb && !trail_stb, "R1", "strobes in reset", lead_stb | trail_stb, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) tick(1'b0);

    // R4: basic, cpol 0, active-low select
    set_cfg(1, 2, 0, 0, 0, 3);
    run_txn("R4 basic");

    // R2: all fields zero, single bit
    set_cfg(0, 0, 0, 0, 0, 0);
    run_txn("R2 zero fields");

    // R9: cpol 1, active-high select, asymmetric phases
    cpol = 1'b1; cs_active_high = 1'b1;
    tick(1'b0);
    set_cfg(0, 3, 2, 1, 4, 1);
    run_txn("R9 cpol1 cshigh");

    // R10: narrow mode ignores upper bits
    cpol = 1'b0; cs_active_high = 1'b0;
    ext_mode = 1'b0;
    set_cfg(16'h0102, 16'h0100, 16'h0203, 16'h0101, 1, 1);
    run_txn("R10 narrow");
    ext_mode = 1'b1;
    set_cfg(16'h0102, 1, 16'h0100, 0, 0, 0);
    run_txn("R10 wide");
    ext_mode = 1'b0;

    // R6: start held high, colliding with the last idle-gap cycle
    set_cfg(0, 0, 1, 0, 2, 1);
    n_push = 0; busy_rises = 0;
    for (int i = 0; i < 60; i++) tick(1'b1);
    while (model_q.size() != 0) tick(1'b0);
    check(busy_rises == n_push, "R6", "accepted back-to-back transactions", busy_rises, n_push);
    check(n_push >= 3, "R6", "transactions started with start held", n_push, 3);

    // R7: extra starts mid-transaction are ignored
    set_cfg(2, 2, 1, 1, 1, 2);
    exp_lead = 3;
    txn_pol = cs_active_high; seen_lead = 0;
    tick(1'b1);
    for (int i = 0; i < 5; i++) tick(1'b1);
    while (model_q.size() != 0) tick(1'b0);
    check(seen_lead == exp_lead, "R7", "lead count with starts while busy", seen_lead, exp_lead);

    // R11: configuration changed during a transaction
    set_cfg(1, 1, 0, 0, 1, 2);
    exp_lead = 3;
    txn_pol = cs_active_high; seen_lead = 0;
    tick(1'b1);
    repeat (3) tick(1'b0);
    set_cfg(5, 5, 5, 5, 5, 7);
    ext_mode = 1'b1;
    while (model_q.size() != 0) tick(1'b0);
    check(seen_lead == exp_lead, "R11", "lead count after mid-change", seen_lead, exp_lead);
    cpol = 1'b1;
    repeat (2) tick(1'b0);
    check(sck == 1'b1, "R1", "idle sck follows cpol at rest", sck, 1);

    finish_run();
  end

endmodule